// File: doc/BRIEF.md
# Scan Chain User Register Interface

This block is the glue between a test access port controller and two scan data registers built in ordinary fabric logic. It watches the controller's current state and instruction, decodes two reserved instruction codes into select strobes for the fabric, and hands the fabric a gated data-register clock that only toggles while one of those registers is being captured or shifted. It also produces an active-low idle indication, which is the NAND of TCK and the Run-Test/Idle state.

On the serial side, the block owns the single-bit bypass register and the test data output multiplexer. While a user instruction is current, the serial stream returned from the fabric for that instruction is sent to the output. Every other instruction code falls through to bypass. In Shift-IR the instruction register's serial output is forwarded instead. The output is retimed on the falling edge of TCK, and its enable is low outside the two shift states.

Top module: `jtag_user_dr_mux`

## Requirements
- R1: `sel1` is high exactly while `ir` equals USER1_CODE (default 4'h2, with a 4-bit `ir`).
- R2: `sel2` is high exactly while `ir` equals USER2_CODE (default 4'h3).
- R3: In Shift-DR (`tap_state` 4'h2) with `sel1` high, each falling TCK edge loads `user1_so` into `tdo`.
- R4: In Shift-DR with `sel2` high, each falling TCK edge loads `user2_so` into `tdo`.
- R5: When neither user code is current, bypass is selected. The bypass flop loads 0 on a rising TCK edge in Capture-DR (4'h6) and loads `tdi` on a rising edge in Shift-DR. In Shift-DR, the falling edge loads the bypass flop into `tdo`.
- R6: In Shift-IR (4'hA), each falling TCK edge loads `ir_so` into `tdo`.
- R7: `tdo_oe` is loaded on each falling TCK edge. It goes high if the state is Shift-DR or Shift-IR, and low for every other state.
- R8: `drck` is low while TCK is low. During a TCK high phase, `drck` follows TCK only if the previous low phase saw a user instruction together with Capture-DR or Shift-DR.
- R9: `idle_n` is the NAND of TCK and (`tap_state` == Run-Test/Idle, 4'hC).
- R10: While `trst_n` is low, `tdo_oe`, `drck` and the bypass flop are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tap_state | input | 4 | Current controller state code |
| ir | input | IR_W | Current instruction |
| tdi | input | 1 | Serial test data in |
| ir_so | input | 1 | Serial output of the instruction register |
| user1_so | input | 1 | Serial stream returned by user register 1 |
| user2_so | input | 1 | Serial stream returned by user register 2 |
| sel1 | output | 1 | User instruction 1 is current |
| sel2 | output | 1 | User instruction 2 is current |
| drck | output | 1 | Gated data-register clock for fabric |
| idle_n | output | 1 | NAND of TCK and Run-Test/Idle |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for tdo |

## Verification
The bypass flop and the falling-edge clock enable are the only hidden state in the block. A fault in either one shows up at the ports within one TCK period. A bad bypass value reaches `tdo` on the next falling edge in Shift-DR. A stuck or late gate enable shows up as a missing or extra `drck` high phase on the very next rising edge. The bench sweeps every state code against every instruction code with random serial inputs and predicts each port one edge at a time. It then runs directed bypass capture-and-shift sequences.

// File: rtl/jtag_user_dr_mux.sv
module jtag_user_dr_mux #(
  parameter int unsigned         IR_W         = 4,
  parameter logic [IR_W-1:0]     USER1_CODE   = 'h2,
  parameter logic [IR_W-1:0]     USER2_CODE   = 'h3,
  parameter logic [3:0]          ST_IDLE      = 4'hC,
  parameter logic [3:0]          ST_CAPTURE_DR = 4'h6,
  parameter logic [3:0]          ST_SHIFT_DR  = 4'h2,
  parameter logic [3:0]          ST_SHIFT_IR  = 4'hA
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic [3:0]      tap_state,
  input  logic [IR_W-1:0] ir,
  input  logic            tdi,
  input  logic            ir_so,
  input  logic            user1_so,
  input  logic            user2_so,
  output logic            sel1,
  output logic            sel2,
  output logic            drck,
  output logic            idle_n,
  output logic            tdo,
  output logic            tdo_oe
);

  logic in_cap, in_shdr, in_shir, user_sel;
  logic bypass_q, gate_q, tdo_q, oe_q;

  assign sel1     = (ir == USER1_CODE);
  assign sel2     = (ir == USER2_CODE);
  assign user_sel = sel1 | sel2;
  assign in_cap   = (tap_state == ST_CAPTURE_DR);
  assign in_shdr  = (tap_state == ST_SHIFT_DR);
  assign in_shir  = (tap_state == ST_SHIFT_IR);
  assign idle_n   = ~(tck & (tap_state == ST_IDLE));

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 bypass_q <= 1'b0;
    else if (!user_sel && in_cap)  bypass_q <= 1'b0;
    else if (!user_sel && in_shdr) bypass_q <= tdi;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) gate_q <= 1'b0;
    else         gate_q <= user_sel & (in_cap | in_shdr);
  end

  assign drck = tck & gate_q;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= in_shdr | in_shir;
      if (in_shir)      tdo_q <= ir_so;
      else if (in_shdr) tdo_q <= sel1 ? user1_so : (sel2 ? user2_so : bypass_q);
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

endmodule

// File: rtl/jtag_user_dr_mux_chk.sv
module jtag_user_dr_mux_chk #(
  parameter logic [3:0] ST_CAPTURE_DR = 4'h6,
  parameter logic [3:0] ST_SHIFT_DR   = 4'h2,
  parameter logic [3:0] ST_SHIFT_IR   = 4'hA
) (
  input logic       tck,
  input logic       trst_n,
  input logic [3:0] tap_state,
  input logic       sel1,
  input logic       sel2,
  input logic       tdi,
  input logic       ir_so,
  input logic       user1_so,
  input logic       user2_so,
  input logic       tdo,
  input logic       tdo_oe,
  input logic       bypass_q
);

  assert_user1_tdo_R3: assert property (@(negedge tck) disable iff (!trst_n)
    (tap_state == ST_SHIFT_DR && sel1) |=> (tdo == $past(user1_so)));

  assert_user2_tdo_R4: assert property (@(negedge tck) disable iff (!trst_n)
    (tap_state == ST_SHIFT_DR && sel2 && !sel1) |=> (tdo == $past(user2_so)));

  assert_bypass_shift_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == ST_SHIFT_DR && !sel1 && !sel2) |=> (bypass_q == $past(tdi)));

  assert_bypass_capture_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == ST_CAPTURE_DR && !sel1 && !sel2) |=> !bypass_q);

  assert_ir_tdo_R6: assert property (@(negedge tck) disable iff (!trst_n)
    (tap_state == ST_SHIFT_IR) |=> (tdo == $past(ir_so)));

  assert_oe_off_R7: assert property (@(negedge tck) disable iff (!trst_n)
    (tap_state != ST_SHIFT_DR && tap_state != ST_SHIFT_IR) |=> !tdo_oe);

endmodule

bind jtag_user_dr_mux jtag_user_dr_mux_chk #(
  .ST_CAPTURE_DR(ST_CAPTURE_DR), .ST_SHIFT_DR(ST_SHIFT_DR), .ST_SHIFT_IR(ST_SHIFT_IR)
) u_chk (
  .tck(tck), .trst_n(trst_n), .tap_state(tap_state), .sel1(sel1), .sel2(sel2),
  .tdi(tdi), .ir_so(ir_so), .user1_so(user1_so), .user2_so(user2_so),
  .tdo(tdo), .tdo_oe(tdo_oe), .bypass_q(bypass_q)
);

// File: tb/jtag_user_dr_mux_tb.sv
module jtag_user_dr_mux_tb;
  localparam logic [3:0] IDLE = 4'hC, CAP = 4'h6, SHDR = 4'h2, SHIR = 4'hA;
  localparam logic [3:0] U1 = 4'h2, U2 = 4'h3;

  logic tck = 1'b0, trst_n = 1'b0;
  logic [3:0] tap_state = 4'h0, ir = 4'hF;
  logic tdi = 0, ir_so = 0, user1_so = 0, user2_so = 0;
  logic sel1, sel2, drck, idle_n, tdo, tdo_oe;

  int checks = 0, errors = 0;
  logic mdl_byp = 1'b0, mdl_gate = 1'b0;

  jtag_user_dr_mux u_dut (
    .tck(tck), .trst_n(trst_n), .tap_state(tap_state), .ir(ir), .tdi(tdi),
    .ir_so(ir_so), .user1_so(user1_so), .user2_so(user2_so), .sel1(sel1),
    .sel2(sel2), .drck(drck), .idle_n(idle_n), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  always #4 tck = ~tck;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b st=%h ir=%h t=%0t", req, act, exp, tap_state, ir, $time);
    end
  endtask

  task automatic cycle(input logic [3:0] st, input logic [3:0] code, input logic d,
                       input logic a, input logic b, input logic s);
    logic u, e_tdo;
    @(posedge tck);
    #1;
    tap_state = st; ir = code; tdi = d; user1_so = a; user2_so = b; ir_so = s;
    #1;
    chk("R1 sel1", sel1, code == U1);
    chk("R2 sel2", sel2, code == U2);
    chk("R9 idle_n high phase", idle_n, !(st == IDLE));
    chk("R8 drck high phase", drck, mdl_gate);
    @(negedge tck);
    #1;
    u = (code == U1) || (code == U2);
    chk("R7 tdo_oe", tdo_oe, st == SHDR || st == SHIR);
    chk("R8 drck low phase", drck, 1'b0);
    chk("R9 idle_n low phase", idle_n, 1'b1);
    if (st == SHIR || st == SHDR) begin
      if (st == SHIR) e_tdo = s;
      else if (code == U1) e_tdo = a;
      else if (code == U2) e_tdo = b;
      else e_tdo = mdl_byp;
      chk(st == SHIR ? "R6 tdo ir" : (code == U1 ? "R3 tdo user1" :
          (code == U2 ? "R4 tdo user2" : "R5 tdo bypass")), tdo, e_tdo);
    end
    mdl_gate = u && (st == CAP || st == SHDR);
    if (!u && st == CAP) mdl_byp = 1'b0;
    else if (!u && st == SHDR) mdl_byp = d;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tap_state = SHDR; ir = U1;
    repeat (3) @(negedge tck);
    #1;
    chk("R10 tdo_oe in reset", tdo_oe, 1'b0);
    chk("R10 drck in reset", drck, 1'b0);
    @(posedge tck); #2;
    chk("R10 drck in reset high", drck, 1'b0);
    @(negedge tck);
    tap_state = 4'h0; ir = 4'hF;
    trst_n = 1'b1;
    // R10: bypass reset value observed in first shift
    cycle(SHDR, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 16; c++)
        cycle(s[3:0], c[3:0], 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    // R5 directed: capture then shift through bypass with unknown codes
    for (int k = 0; k < 4; k++) begin
      cycle(CAP, 4'hE - k[3:0], 1'b1, 1'b1, 1'b1, 1'b1);
      for (int j = 0; j < 8; j++)
        cycle(SHDR, 4'h8 + k[3:0], 1'(j ^ k), 1'b0, 1'b1, 1'b0);
    end
    // R3 R4 R8 directed: long user shifts with drck
    for (int j = 0; j < 10; j++) cycle(SHDR, U1, 1'b0, 1'(j), 1'(~j), 1'b0);
    for (int j = 0; j < 10; j++) cycle(SHDR, U2, 1'b0, 1'(j), 1'(~j), 1'b0);
    cycle(IDLE, U2, 1'b0, 1'b0, 1'b0, 1'b0);
    cycle(IDLE, U2, 1'b0, 1'b0, 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule